// File: doc/BRIEF.md
# Channel Scan Sequencer for a Multiplexed 16-Input A/D Front End

This block chooses which analog input the converter samples next and which gain and input mode that input uses. Software sets a scan window by giving a start channel and a stop channel. A gain write stores a six-bit code for the channel named as the current start channel, so each input keeps its own setting. Each accepted trigger launches one conversion. The block drives a one-cycle launch strobe together with the channel and its stored code, then waits for the converter to answer. The result leaves the block as a 16-bit word. The source channel is in the top four bits and the 12-bit result is in the low bits.

A conversion can be triggered three ways: a software kick write, a tick from an internal pacer, or a rising edge on an external trigger pin. Each way is gated by its own enable bit. The window is scanned in order and wraps back to the start channel after the stop channel. A channel marked differential also uses the odd input above it, so the scan moves on by two after it.

Results leave on a valid/ready stream. A word stays on the output until the consumer accepts it. The block starts no new conversion while a word is waiting or a conversion is running. Triggers that arrive in that time are dropped and are not queued.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block drives no launch strobe and no valid sample, all three trigger enables are off, every stored gain code is 0, and the scan pointer is at channel 0.
- R2: A configuration write with selector 0 sets the start channel from data bits 3:0 and the stop channel from data bits 11:8. It also moves the scan pointer to the start channel.
- R3: A configuration write with selector 1 stores data bits 5:0 as the code of the current start channel. Bit 5 marks the channel as differential and bits 4:0 are the gain code. The code of a channel appears on the range output whenever that channel is launched.
- R4: For an odd-numbered channel the differential bit is dropped when the code is stored, so that channel is never launched as differential.
- R5: A configuration write with selector 2 sets the trigger enables from data bits: bit 0 for software, bit 1 for pacer, bit 2 for external. A triggering event is one of: a write with selector 3 while software is enabled, a high pacer tick while pacer is enabled, or a low-to-high change of the external pin while external is enabled. An event from a source that is not enabled has no effect.
- R6: The cycle after an accepted trigger, the launch strobe is high for exactly one cycle. The channel and range outputs show the pointer's channel and its stored code, and they hold steady until the conversion completes.
- R7: A trigger that arrives while a conversion is running, or while an output word is still waiting, is dropped.
- R8: The cycle after the converter's done signal during a conversion, the output becomes valid with bits 15:12 equal to the launched channel and bits 11:0 equal to the converter data. A done signal when no conversion is running is ignored.
- R9: After a conversion the pointer moves to the next channel, or two channels on for a differential channel, modulo 16. If the converted channel is the stop channel, or a differential pair covers the stop channel, the pointer goes back to the start channel instead.
- R10: While the output is valid and ready is low, valid stays high and the data stays unchanged. A cycle with both valid and ready high clears valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 window, 1 gain code, 2 trigger enables, 3 software kick |
| cfg_wdata | input | 16 | Write data |
| pacer_tick | input | 1 | Internal pacer tick |
| ext_trig | input | 1 | External trigger pin, rising-edge sensitive |
| conv_start | output | 1 | One-cycle conversion launch strobe |
| conv_chan | output | 4 | Channel being converted |
| conv_range | output | 6 | Stored code for that channel |
| conv_done | input | 1 | Converter result ready |
| conv_data | input | 12 | Converter result |
| smp_valid | output | 1 | Tagged sample valid |
| smp_ready | input | 1 | Consumer accepts sample |
| smp_data | output | 16 | Channel tag and result |

## Verification
Two pairs of events can land in the same cycle. A new trigger can meet a conversion that is still running or a sample that is still waiting. The bench fires software, pacer and external triggers inside those windows and checks at the ports that no launch strobe follows. A scan step can also meet the wrap rule when a differential pair ends exactly on the stop channel. Directed windows set that case up, and the launched channel sequence is compared with a reference model kept in the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEL_SCAN = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KICK = 2'd3
  } cfg_sel_e;

  localparam int TRIG_SRC_N = 3;
  localparam int EN_SW      = 0;
  localparam int EN_PACER   = 1;
  localparam int EN_EXT     = 2;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_wr,
  input  logic [TRIG_SRC_N-1:0] ctrl_bits,
  input  logic                  kick_wr,
  input  logic                  pacer_tick,
  input  logic                  ext_trig,
  output logic                  trig_evt
);
  logic [TRIG_SRC_N-1:0] en_q;
  logic                  ext_prev;
  logic [TRIG_SRC_N-1:0] raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_prev <= ext_trig;
      if (ctrl_wr) en_q <= ctrl_bits;
    end
  end

  always_comb begin
    raw           = '0;
    raw[EN_SW]    = kick_wr;
    raw[EN_PACER] = pacer_tick;
    raw[EN_EXT]   = ext_trig & ~ext_prev;
  end

  assign trig_evt = |(raw & en_q);
endmodule

// File: rtl/adc_range_tbl.sv
module adc_range_tbl #(
  parameter int NCH     = 16,
  parameter int RANGE_W = 6,
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_chan,
  input  logic [RANGE_W-1:0] wr_code,
  input  logic [CH_W-1:0]    rd_chan,
  output logic [RANGE_W-1:0] rd_code
);
  localparam int DIFF_BIT = RANGE_W - 1;
  logic [RANGE_W-1:0] tbl [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [RANGE_W-1:0] wr_masked;
    if (i % 2 == 1) begin : g_odd
      assign wr_masked = {1'b0, wr_code[RANGE_W-2:0]};
    end else begin : g_even
      assign wr_masked = wr_code;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl[i] <= '0;
      else if (wr_en && wr_chan == CH_W'(i)) tbl[i] <= wr_masked;
    end
  end

  assign rd_code = tbl[rd_chan];

  AST_ODD_NEVER_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_chan[0] |-> !rd_code[DIFF_BIT]); // R4
endmodule

// File: rtl/adc_scan_ptr.sv
module adc_scan_ptr #(
  parameter int NCH   = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_wr,
  input  logic [CH_W-1:0] win_first,
  input  logic [CH_W-1:0] win_last,
  input  logic            trig,
  input  logic            out_free,
  input  logic            done,
  input  logic            act_diff,
  output logic [CH_W-1:0] ptr,
  output logic [CH_W-1:0] first_q,
  output logic [CH_W-1:0] act_chan,
  output logic            busy,
  output logic            conv_start,
  output logic            launch,
  output logic            finish
);
  logic [CH_W-1:0] last_q;
  logic [CH_W-1:0] step_nxt;
  logic [CH_W-1:0] ptr_nxt;
  logic            rewound;

  assign launch = trig && !busy && out_free;
  assign finish = done && busy;

  always_comb begin
    step_nxt = act_chan + (act_diff ? CH_W'(2) : CH_W'(1));
    if (act_chan == last_q || (act_diff && (act_chan + CH_W'(1)) == last_q))
      ptr_nxt = first_q;
    else
      ptr_nxt = step_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= '0;
      last_q     <= '0;
      ptr        <= '0;
      act_chan   <= '0;
      busy       <= 1'b0;
      conv_start <= 1'b0;
      rewound    <= 1'b0;
    end else begin
      conv_start <= launch;
      if (launch) begin
        busy     <= 1'b1;
        act_chan <= ptr;
        rewound  <= 1'b0;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (win_wr) begin
        first_q <= win_first;
        last_q  <= win_last;
        ptr     <= win_first;
        if (busy) rewound <= 1'b1;
      end else if (finish && !rewound) begin
        ptr <= ptr_nxt;
      end
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R6
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> $stable(act_chan)); // R6
  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R7
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int DATA_W  = 12,
  parameter int RANGE_W = 6,
  localparam int CH_W   = $clog2(NCH),
  localparam int SMP_W  = CH_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [15:0]        cfg_wdata,
  input  logic               pacer_tick,
  input  logic               ext_trig,
  output logic               conv_start,
  output logic [CH_W-1:0]    conv_chan,
  output logic [RANGE_W-1:0] conv_range,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  output logic               smp_valid,
  input  logic               smp_ready,
  output logic [SMP_W-1:0]   smp_data
);
  cfg_sel_e        sel;
  logic            wr_scan, wr_gain, wr_ctrl, wr_kick;
  logic            trig_evt;
  logic [CH_W-1:0] ptr, first_q, act_chan;
  logic            busy, launch, finish;
  logic [RANGE_W-1:0] tbl_code;
  logic [RANGE_W-1:0] range_q;

  assign sel     = cfg_sel_e'(cfg_sel);
  assign wr_scan = cfg_wr && sel == SEL_SCAN;
  assign wr_gain = cfg_wr && sel == SEL_GAIN;
  assign wr_ctrl = cfg_wr && sel == SEL_CTRL;
  assign wr_kick = cfg_wr && sel == SEL_KICK;

  adc_trig_sel u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_ctrl),
    .ctrl_bits  (cfg_wdata[TRIG_SRC_N-1:0]),
    .kick_wr    (wr_kick),
    .pacer_tick (pacer_tick),
    .ext_trig   (ext_trig),
    .trig_evt   (trig_evt)
  );

  adc_range_tbl #(.NCH(NCH), .RANGE_W(RANGE_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_gain),
    .wr_chan (first_q),
    .wr_code (cfg_wdata[RANGE_W-1:0]),
    .rd_chan (ptr),
    .rd_code (tbl_code)
  );

  adc_scan_ptr #(.NCH(NCH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_wr     (wr_scan),
    .win_first  (cfg_wdata[CH_W-1:0]),
    .win_last   (cfg_wdata[8+CH_W-1:8]),
    .trig       (trig_evt),
    .out_free   (!smp_valid),
    .done       (conv_done),
    .act_diff   (range_q[RANGE_W-1]),
    .ptr        (ptr),
    .first_q    (first_q),
    .act_chan   (act_chan),
    .busy       (busy),
    .conv_start (conv_start),
    .launch     (launch),
    .finish     (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q   <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      if (launch) range_q <= tbl_code;
      if (finish) begin
        smp_valid <= 1'b1;
        smp_data  <= {act_chan, conv_data};
      end else if (smp_valid && smp_ready) begin
        smp_valid <= 1'b0;
      end
    end
  end

  assign conv_chan  = act_chan;
  assign conv_range = range_q;

  AST_SMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data)); // R10
  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && busy |=> smp_data[SMP_W-1:DATA_W] == $past(conv_chan)); // R8
  AST_NO_LAUNCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !conv_start); // R7
  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> $stable(conv_range)); // R6
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        pacer_tick = 1'b0;
  logic        ext_trig = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic [5:0]  conv_range;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [15:0] smp_data;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [3:0] m_first = 0, m_last = 0, m_ptr = 0;
  logic [5:0] m_rng [16];

  always #5 clk = ~clk;

  adc_scan_seq dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] next_ptr(logic [3:0] c);
    logic d;
    d = m_rng[c][5];
    if (c == m_last || (d && 4'(c + 1) == m_last)) return m_first;
    return 4'(c + (d ? 4'd2 : 4'd1));
  endfunction

  function automatic logic [5:0] stored(logic [3:0] ch, logic [5:0] code);
    return ch[0] ? {1'b0, code[4:0]} : code;
  endfunction

  task automatic wr(logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_win(logic [3:0] f, logic [3:0] l);
    wr(2'd0, {4'd0, l, 4'd0, f});
    m_first = f; m_last = l; m_ptr = f;
  endtask

  task automatic set_gain(logic [3:0] ch, logic [5:0] code);
    set_win(ch, ch);
    wr(2'd1, {10'd0, code});
    m_rng[ch] = stored(ch, code);
  endtask

  // fire one trigger of the given source; returns at the negedge after the edge
  task automatic fire(int src);
    @(negedge clk);
    case (src)
      0: begin cfg_wr = 1'b1; cfg_sel = 2'd3; end
      1: pacer_tick = 1'b1;
      default: ext_trig = 1'b1;
    endcase
    @(negedge clk);
    cfg_wr = 1'b0; pacer_tick = 1'b0; ext_trig = 1'b0;
  endtask

  task automatic conv(int src, int dly, int bp);
    logic [11:0] d;
    logic [3:0]  ch;
    fire(src);
    ch = m_ptr;
    check("R6 start", conv_start, 1);
    check("R6 chan", conv_chan, ch);
    check("R3 range", conv_range, m_rng[ch]);
    @(negedge clk);
    check("R6 one-cycle", conv_start, 0);
    repeat (dly) @(negedge clk);
    d = 12'($urandom);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
    check("R8 valid", smp_valid, 1);
    check("R8 word", smp_data, {ch, d});
    m_ptr = next_ptr(ch);
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      check("R10 hold", {smp_valid, smp_data}, {1'b1, ch, d});
    end
    smp_ready = 1'b1;
    @(negedge clk);
    smp_ready = 1'b0;
    check("R10 drain", smp_valid, 0);
  endtask

  task automatic expect_seq(logic [3:0] c0, logic [3:0] c1, logic [3:0] c2, logic [3:0] c3);
    logic [3:0] e [4];
    e[0] = c0; e[1] = c1; e[2] = c2; e[3] = c3;
    for (int i = 0; i < 4; i++) begin
      fire(0);
      check("R9 sequence", conv_chan, e[i]);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      smp_ready = 1'b1;
      @(negedge clk);
      smp_ready = 1'b0;
      m_ptr = next_ptr(e[i]);
    end
  endtask

  initial begin
    repeat (4000) @(negedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_rng[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 start", conv_start, 0);
    check("R1 valid", smp_valid, 0);
    // all sources disabled after reset
    fire(0); check("R1 sw disabled", conv_start, 0);
    fire(1); check("R1 pacer disabled", conv_start, 0);
    fire(2); check("R1 ext disabled", conv_start, 0);
    // software only
    wr(2'd2, 16'h0001);
    fire(1); check("R5 pacer gated", conv_start, 0);
    fire(2); check("R5 ext gated", conv_start, 0);
    conv(0, 0, 0);
    check("R1 ptr0 range", m_rng[0], 0);
    wr(2'd2, 16'h0007);
    // done while idle ignored
    @(negedge clk); conv_done = 1'b1; conv_data = 12'hABC;
    @(negedge clk); conv_done = 1'b0;
    check("R8 idle done", smp_valid, 0);
    // odd channel differential dropped, even kept
    set_gain(4'd3, 6'h21);
    set_win(4'd3, 4'd3);
    conv(1, 1, 0);
    check("R4 odd diff", m_rng[3], 6'h01);
    set_gain(4'd2, 6'h33);
    set_win(4'd2, 4'd2);
    conv(2, 0, 1);
    // triggers dropped while busy and while pending
    fire(0);
    check("R7 launch", conv_start, 1);
    fire(1); check("R7 busy pacer", conv_start, 0);
    fire(0); check("R7 busy sw", conv_start, 0);
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    check("R8 after busy", smp_valid, 1);
    m_ptr = next_ptr(m_ptr);
    fire(2); check("R7 pending ext", conv_start, 0);
    fire(0); check("R7 pending sw", conv_start, 0);
    smp_ready = 1'b1; @(negedge clk); smp_ready = 1'b0;
    // diff step inside window
    set_gain(4'd2, 6'h22);
    set_win(4'd2, 4'd5);
    expect_seq(4'd2, 4'd4, 4'd5, 4'd2);
    // diff pair covering stop channel
    set_win(4'd0, 4'd3);
    expect_seq(4'd0, 4'd1, 4'd2, 4'd0);
    // modulo-16 wrap
    set_gain(4'd14, 6'h04);
    set_win(4'd14, 4'd1);
    expect_seq(4'd14, 4'd15, 4'd0, 4'd1);
    check("R2 rewind", m_ptr, 4'd14);
    // random
    for (int n = 0; n < 60; n++) begin
      if (n % 10 == 0) begin
        for (int k = 0; k < 3; k++) begin
          logic [5:0] c;
          c = ($urandom % 2) ? 6'($urandom % 8) : 6'(6'h10 + $urandom % 4);
          if ($urandom % 2) c[5] = 1'b1;
          set_gain(4'($urandom), c);
        end
        set_win(4'($urandom), 4'($urandom));
      end
      conv(int'($urandom % 3), int'($urandom % 4), int'($urandom % 4));
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule